// File: doc/BRIEF.md
# DDR Memory Power-Up Command Sequencer

This block brings a DRAM controller out of reset by issuing a fixed series of register writes to the controller's control register and mode register. It drives a simple write port with four signals: a one-bit register select, a data word, a write strobe, and a ready return. Each command is held on the port until the port accepts it. A programmable number of idle cycles then passes before the next command is presented.

The control, mode and extended-mode words are parameters. A parameter also selects between two variants. The double-data-rate variant includes an extended-mode write and a DLL-reset write. The single-data-rate variant drops both. A high-address select input adds one extra bit to every control write. Software or a boot state machine pulses `start_i`, waits for the `done_o` pulse, and then uses the controller normally.

Top module: `mem_init_seq`

## Requirements
- R1: After reset, `wr_strobe_o`, `busy_o` and `done_o` are all low. The strobe is never high while `busy_o` is low.
- R2: In the double-data-rate variant, a `start_i` pulse seen while idle produces exactly 8 accepted writes, in this order:
  - control unlock
  - precharge-all
  - extended-mode word to the mode register
  - mode word OR bit 26 (DLL reset) to the mode register
  - precharge-all
  - auto-refresh
  - plain mode word to the mode register
  - control return-to-normal

  The first strobe appears in the cycle after `start_i` is sampled.
- R3: Control-word encodings, where `wr_sel_o` = 0 selects the control register and 1 selects the mode register:
  - unlock is base OR bit 31
  - precharge-all is base OR bit 31 OR 2
  - auto-refresh is base OR bit 31 OR 4
  - the final return-to-normal word is the base word with bit 31 cleared
- R4: When the high-address select is set, bit 24 is ORed into every control write. Mode-register writes never carry it.
- R5: In the single-data-rate variant, the extended-mode and DLL-reset writes are skipped. The remaining 6 writes keep their relative order.
- R6: While the strobe is high and `wr_ready_i` is low, the strobe stays high and the select and data stay unchanged.
- R7: Between the acceptance of one write and the strobe of the next, the strobe is low for exactly G cycles, where G is the gap value. When G = 0, the writes follow back-to-back.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running sequence continues unchanged.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final write is accepted. `busy_o` is low in that same cycle.
- R10: The gap value and the high-address select are captured when the sequence starts. Changes to them during the run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the sequence (honoured only when idle) |
| hi_addr_i | input | 1 | High-address select, captured at start |
| gap_i | input | GAP_W | Idle cycles between commands, captured at start |
| wr_sel_o | output | 1 | Register select: 0 = control, 1 = mode |
| wr_data_o | output | DW | Word to be written |
| wr_strobe_o | output | 1 | Write request, held until accepted |
| wr_ready_i | input | 1 | Port accepts the write in this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last write is accepted |

## Verification
A wrong step index shows up at the port on the next strobe as a wrong select or wrong data word. This happens no later than the first strobe after the next acceptance. A wrong phase or a miscounted gap timer shifts the strobe edge: the number of idle cycles between an acceptance and the next strobe stops matching the captured gap. A faulty last-step decode shows as a missing or early `done_o`, or as a write count other than 8 or 6. A corrupted capture of the gap or high-address input shows only after the input is changed in the middle of a run, which the stimulus does on every run.

// File: rtl/mem_init_pkg.sv
package mem_init_pkg;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_MODE = 1'b1
   } wr_sel_e;

   // Step order is behaviour: the sequencer walks these in ascending order.
   typedef enum logic [2:0] {
      ST_UNLOCK   = 3'd0,
      ST_PRE_A    = 3'd1,
      ST_EXT_MODE = 3'd2,
      ST_DLL_RST  = 3'd3,
      ST_PRE_B    = 3'd4,
      ST_REFRESH  = 3'd5,
      ST_MODE_SET = 3'd6,
      ST_NORMAL   = 3'd7
   } step_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WRITE = 2'd1,
      PH_GAP   = 2'd2
   } phase_e;

endpackage

// File: rtl/mem_init_word_gen.sv
// Combinational mapping from a sequence step to register select and data.
module mem_init_word_gen
   import mem_init_pkg::*;
#(
   parameter int unsigned    DW         = 32,
   parameter logic [DW-1:0]  BASE_WORD  = '0,
   parameter logic [DW-1:0]  MODE_WORD  = '0,
   parameter logic [DW-1:0]  EMODE_WORD = '0,
   parameter int unsigned    UNLOCK_BIT = 31,
   parameter int unsigned    HI_BIT     = 24,
   parameter int unsigned    DLL_BIT    = 26,
   parameter logic [DW-1:0]  PRE_CODE   = 2,
   parameter logic [DW-1:0]  REF_CODE   = 4
) (
   input  step_e          step_i,
   input  logic           hi_i,
   output wr_sel_e        sel_o,
   output logic [DW-1:0]  data_o
);

   localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] UNLOCK_M = ONE << UNLOCK_BIT;
   localparam logic [DW-1:0] HI_M     = ONE << HI_BIT;
   localparam logic [DW-1:0] DLL_M    = ONE << DLL_BIT;
   localparam logic [DW-1:0] CMD_BASE = BASE_WORD | UNLOCK_M;

   logic [DW-1:0] raw;

   always_comb begin
      sel_o = SEL_CTRL;
      raw   = CMD_BASE;
      unique case (step_i)
         ST_UNLOCK:   raw = CMD_BASE;
         ST_PRE_A:    raw = CMD_BASE | PRE_CODE;
         ST_EXT_MODE: begin sel_o = SEL_MODE; raw = EMODE_WORD; end
         ST_DLL_RST:  begin sel_o = SEL_MODE; raw = MODE_WORD | DLL_M; end
         ST_PRE_B:    raw = CMD_BASE | PRE_CODE;
         ST_REFRESH:  raw = CMD_BASE | REF_CODE;
         ST_MODE_SET: begin sel_o = SEL_MODE; raw = MODE_WORD; end
         ST_NORMAL:   raw = BASE_WORD & ~UNLOCK_M;
         default:     raw = CMD_BASE;
      endcase
   end

   assign data_o = raw | ((sel_o == SEL_CTRL && hi_i) ? HI_M : '0);

endmodule

// File: rtl/mem_init_step_seq.sv
// Next-step and last-step decode; the variant picks whether mode-setup steps run.
module mem_init_step_seq
   import mem_init_pkg::*;
#(
   parameter bit DDR_EN = 1'b1
) (
   input  step_e  cur_i,
   output step_e  nxt_o,
   output logic   last_o
);

   step_e inc;
   assign inc = step_e'(cur_i + 3'd1);

   generate
      if (DDR_EN) begin : g_ddr
         assign nxt_o = inc;
      end else begin : g_sdr
         assign nxt_o = (cur_i == ST_PRE_A) ? ST_PRE_B : inc;
      end
   endgenerate

   assign last_o = (cur_i == ST_NORMAL);

endmodule

// File: rtl/mem_init_gap_timer.sv
// Down counter for the idle gap; expire_o marks the final idle cycle.
module mem_init_gap_timer #(
   parameter int unsigned GAP_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [GAP_W-1:0]  val_i,
   output logic              expire_o
);

   localparam logic [GAP_W-1:0] CNT_ONE = {{(GAP_W-1){1'b0}}, 1'b1};

   logic [GAP_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign expire_o = (cnt_q == CNT_ONE);

endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
   import mem_init_pkg::*;
#(
   parameter int unsigned    DW         = 32,
   parameter int unsigned    GAP_W      = 4,
   parameter bit             DDR_EN     = 1'b1,
   parameter logic [DW-1:0]  BASE_WORD  = 32'h704F_0F00,
   parameter logic [DW-1:0]  MODE_WORD  = 32'h018D_0000,
   parameter logic [DW-1:0]  EMODE_WORD = 32'h4009_0000,
   parameter int unsigned    UNLOCK_BIT = 31,
   parameter int unsigned    HI_BIT     = 24,
   parameter int unsigned    DLL_BIT    = 26,
   parameter logic [DW-1:0]  PRE_CODE   = 2,
   parameter logic [DW-1:0]  REF_CODE   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              hi_addr_i,
   input  logic [GAP_W-1:0]  gap_i,
   output logic              wr_sel_o,
   output logic [DW-1:0]     wr_data_o,
   output logic              wr_strobe_o,
   input  logic              wr_ready_i,
   output logic              busy_o,
   output logic              done_o
);

   localparam int unsigned MAX_BIT = (UNLOCK_BIT > HI_BIT)
                                     ? ((UNLOCK_BIT > DLL_BIT) ? UNLOCK_BIT : DLL_BIT)
                                     : ((HI_BIT > DLL_BIT) ? HI_BIT : DLL_BIT);

   generate
      if (MAX_BIT >= DW) begin : g_bad_bit
         $error("mem_init_seq: a flag bit position lies outside the data word");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("mem_init_seq: GAP_W must be at least 1");
      end
      if (UNLOCK_BIT == HI_BIT || UNLOCK_BIT == DLL_BIT) begin : g_bad_overlap
         $error("mem_init_seq: unlock flag overlaps another flag");
      end
   endgenerate

   phase_e            phase_q;
   step_e             step_q;
   step_e             step_nxt;
   logic              step_last;
   logic              hi_q;
   logic [GAP_W-1:0]  gap_q;
   logic              done_q;
   logic              accept;
   logic              gap_load;
   logic              gap_expire;
   wr_sel_e           sel_w;

   assign accept   = (phase_q == PH_WRITE) && wr_ready_i;
   assign gap_load = accept && !step_last && (gap_q != '0);

   mem_init_step_seq #(
      .DDR_EN (DDR_EN)
   ) seq_i (
      .cur_i  (step_q),
      .nxt_o  (step_nxt),
      .last_o (step_last)
   );

   mem_init_word_gen #(
      .DW         (DW),
      .BASE_WORD  (BASE_WORD),
      .MODE_WORD  (MODE_WORD),
      .EMODE_WORD (EMODE_WORD),
      .UNLOCK_BIT (UNLOCK_BIT),
      .HI_BIT     (HI_BIT),
      .DLL_BIT    (DLL_BIT),
      .PRE_CODE   (PRE_CODE),
      .REF_CODE   (REF_CODE)
   ) word_i (
      .step_i (step_q),
      .hi_i   (hi_q),
      .sel_o  (sel_w),
      .data_o (wr_data_o)
   );

   mem_init_gap_timer #(
      .GAP_W (GAP_W)
   ) gap_i_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (gap_load),
      .val_i    (gap_q),
      .expire_o (gap_expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         step_q  <= ST_UNLOCK;
         hi_q    <= 1'b0;
         gap_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_WRITE;
                  step_q  <= ST_UNLOCK;
                  hi_q    <= hi_addr_i;
                  gap_q   <= gap_i;
               end
            end
            PH_WRITE: begin
               if (wr_ready_i) begin
                  if (step_last) begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     step_q  <= step_nxt;
                     phase_q <= (gap_q == '0) ? PH_WRITE : PH_GAP;
                  end
               end
            end
            PH_GAP: begin
               if (gap_expire) begin
                  phase_q <= PH_WRITE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign wr_sel_o    = sel_w;
   assign wr_strobe_o = (phase_q == PH_WRITE);
   assign busy_o      = (phase_q != PH_IDLE);
   assign done_o      = done_q;

endmodule

// File: rtl/mem_init_seq_chk.sv
module mem_init_seq_chk #(
   parameter int unsigned    DW         = 32,
   parameter logic [DW-1:0]  BASE_WORD  = '0,
   parameter int unsigned    UNLOCK_BIT = 31,
   parameter int unsigned    HI_BIT     = 24
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           start_i,
   input logic           wr_sel_o,
   input logic [DW-1:0]  wr_data_o,
   input logic           wr_strobe_o,
   input logic           wr_ready_i,
   input logic           busy_o,
   input logic           done_o,
   input logic           hi_lat
);

   p_idle_no_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !wr_strobe_o);

   p_start_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> (busy_o && wr_strobe_o));

   p_final_normal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(wr_strobe_o && wr_ready_i && !wr_sel_o && !wr_data_o[UNLOCK_BIT]));

   p_ctrl_hiaddr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_strobe_o && !wr_sel_o) |-> (wr_data_o[HI_BIT] == (hi_lat | BASE_WORD[HI_BIT])));

   p_strobe_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_strobe_o && !wr_ready_i) |=>
         (wr_strobe_o && $stable(wr_data_o) && $stable(wr_sel_o)));

   p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && !wr_strobe_o));

endmodule

bind mem_init_seq mem_init_seq_chk #(
   .DW         (DW),
   .BASE_WORD  (BASE_WORD),
   .UNLOCK_BIT (UNLOCK_BIT),
   .HI_BIT     (HI_BIT)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .wr_sel_o    (wr_sel_o),
   .wr_data_o   (wr_data_o),
   .wr_strobe_o (wr_strobe_o),
   .wr_ready_i  (wr_ready_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .hi_lat      (hi_q)
);

// File: tb/mem_init_seq_tb.sv
`timescale 1ns/1ps
module mem_init_seq_tb_top;

   localparam int unsigned   DW    = 32;
   localparam int unsigned   GAP_W = 4;
   localparam logic [31:0]   BASE  = 32'h704F_0F00;
   localparam logic [31:0]   MODEW = 32'h018D_0000;
   localparam logic [31:0]   EMODE = 32'h4009_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic hi_addr = 1'b0;
   logic [GAP_W-1:0] gap = '0;
   logic ready = 1'b0;

   logic d_sel, s_sel, d_stb, s_stb, d_busy, s_busy, d_done, s_done;
   logic [DW-1:0] d_data, s_data;

   int checks = 0;
   int fails  = 0;
   bit obs_sdr = 1'b0;

   always #2 clk = ~clk;

   mem_init_seq #(.DW(DW), .GAP_W(GAP_W), .DDR_EN(1'b1),
      .BASE_WORD(BASE), .MODE_WORD(MODEW), .EMODE_WORD(EMODE)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hi_addr_i(hi_addr),
      .gap_i(gap), .wr_sel_o(d_sel), .wr_data_o(d_data), .wr_strobe_o(d_stb),
      .wr_ready_i(ready), .busy_o(d_busy), .done_o(d_done));

   mem_init_seq #(.DW(DW), .GAP_W(GAP_W), .DDR_EN(1'b0),
      .BASE_WORD(BASE), .MODE_WORD(MODEW), .EMODE_WORD(EMODE)) dut_sdr_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hi_addr_i(hi_addr),
      .gap_i(gap), .wr_sel_o(s_sel), .wr_data_o(s_data), .wr_strobe_o(s_stb),
      .wr_ready_i(ready), .busy_o(s_busy), .done_o(s_done));

   logic          o_sel, o_stb, o_busy, o_done;
   logic [DW-1:0] o_data;
   assign o_sel  = obs_sdr ? s_sel  : d_sel;
   assign o_data = obs_sdr ? s_data : d_data;
   assign o_stb  = obs_sdr ? s_stb  : d_stb;
   assign o_busy = obs_sdr ? s_busy : d_busy;
   assign o_done = obs_sdr ? s_done : d_done;

   // Expected {select, data} for the k-th accepted write (select 0 = control).
   function automatic logic [32:0] exp_wr(bit sdr, int k, bit hi);
      int s;
      logic sel;
      logic [31:0] d;
      s = (sdr && k >= 2) ? k + 2 : k;
      sel = 1'b0;
      case (s)
         0: d = BASE | 32'h8000_0000;
         1: d = BASE | 32'h8000_0002;
         2: begin sel = 1'b1; d = EMODE; end
         3: begin sel = 1'b1; d = MODEW | 32'h0400_0000; end
         4: d = BASE | 32'h8000_0002;
         5: d = BASE | 32'h8000_0004;
         6: begin sel = 1'b1; d = MODEW; end
         default: d = BASE & 32'h7FFF_FFFF;
      endcase
      if (!sel && hi) d = d | 32'h0100_0000;
      return {sel, d};
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_seq(bit sdr, bit hi, logic [GAP_W-1:0] g, int pct, bit poke);
      int n, idx, idle, cyc;
      bit prev_stb, prev_acc, after_acc, fin, r, poked;
      logic [32:0] prev_w, ew;
      string req;
      obs_sdr = sdr;
      n = sdr ? 6 : 8;
      req = sdr ? (hi ? "R5/R4" : "R5") : (hi ? "R2/R4" : "R2");
      @(negedge clk);
      hi_addr = hi; gap = g; start = 1'b1; ready = 1'b0;
      @(negedge clk);
      start = 1'b0; hi_addr = ~hi; gap = g ^ 4'h5;  // R10: changes after capture
      idx = 0; idle = 0; cyc = 0; fin = 0; poked = 0;
      prev_stb = 0; prev_acc = 0; after_acc = 0; prev_w = '0;
      while (!fin) begin
         if (prev_acc) begin
            idx++; idle = 0; after_acc = 1;
            if (idx == n) begin
               check(o_done && !o_busy, "R9", {o_done, o_busy}, 2'b10);
               fin = 1;
            end
         end else if (idx < n) begin
            check(!o_done, "R9", o_done, 0);
         end
         if (!fin) begin
            if (o_stb) begin
               if (after_acc) check(idle == int'(g), "R7/R10", idle, g);
               after_acc = 0;
               if (prev_stb && !prev_acc)
                  check({o_sel, o_data} == prev_w, "R6", {o_sel, o_data}, prev_w);
               ew = exp_wr(sdr, idx, hi);
               check({o_sel, o_data} == ew, (idx == 0 || idx == n - 1) ? "R3" : req,
                     {o_sel, o_data}, ew);
               if (poke && idx == 2 && !poked) begin start = 1'b1; poked = 1; end  // R8
            end else begin
               if (prev_stb && !prev_acc) check(0, "R6", 0, 1);
               idle++;
            end
            r = ($urandom % 100) < pct;
            ready = r;
            prev_acc = o_stb && r;
            prev_stb = o_stb;
            prev_w = {o_sel, o_data};
         end
         cyc++;
         if (cyc > 3000) begin check(0, "watchdog", cyc, 0); fin = 1; end
         @(negedge clk);
         start = 1'b0;
      end
      ready = 1'b0;
      for (int i = 0; i < 3; i++) begin
         check(!o_done && !o_stb, "R9", {o_done, o_stb}, 0);
         @(negedge clk);
      end
      ready = 1'b1;
      while (d_busy || s_busy) @(negedge clk);
      ready = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(!d_stb && !d_busy && !d_done && !s_stb && !s_busy && !s_done, "R1",
            {d_stb, d_busy, d_done, s_stb, s_busy, s_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!d_stb && !d_busy && !d_done, "R1", {d_stb, d_busy, d_done}, 0);
      run_seq(0, 0, 4'd0, 100, 0);
      run_seq(0, 1, 4'd3, 100, 1);
      run_seq(1, 0, 4'd1, 100, 0);
      run_seq(1, 1, 4'd0, 40, 1);
      run_seq(0, 1, 4'd15, 30, 1);
      run_seq(0, 0, 4'd2, 25, 0);
      for (int i = 0; i < 14; i++) begin
         run_seq(bit'($urandom % 2), bit'($urandom % 2), 4'($urandom % 16),
                 20 + int'($urandom % 81), bit'($urandom % 2));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule